// File: doc/BRIEF.md
# Dual-Issue Pairing Controller

This block sits between instruction decode and two execution pipes of an in-order core: a full pipe (U) that accepts any instruction and a restricted pipe (V) that accepts only simple classes. Each cycle it sees the next two instructions in program order as packed descriptors. It decides whether both go out together, only the older one goes to U, or nothing goes out because of a stall. The descriptor gives the instruction class, the destination and source registers, the address base and index registers, memory-operand flags, a displacement flag, a memory-cycle count and a taken-transfer flag.

Stalls come from two sources. An address-generation interlock occurs when a register written in the previous issue cycle is used as an address base or index. Lockstep occurs when a paired read-modify-write memory operation takes several memory cycles. A small history register holds the registers written in the last cycle. A counter tracks the remaining lockstep cycles.

The descriptor interface is a valid/ready stream in which the ready side is the `consumed` count. Upstream presents the oldest instruction on the U slot and the next one on the V slot, each with its own valid. It must hold both descriptors unchanged while `consumed` is 0. After `consumed` is 1, the old V-slot instruction moves into the U slot. After `consumed` is 2, two new instructions are presented. A V-slot valid without a U-slot valid is ignored.

Top module: `dual_issue_ctrl`

## Requirements
- R1: Descriptor bits are laid out as follows:
  - class in [4:0];
  - destination enable [5] and destination register [8:6];
  - source A enable [9] and register [12:10];
  - source B enable [13] and register [16:14];
  - base enable [17] and base register [20:18];
  - index enable [21] and index register [24:22];
  - memory operand [25], memory destination [26] and displacement [27];
  - memory-cycle count [29:28];
  - taken transfer [30].

  Class codes are: MOV 0, AND 1, OR 2, XOR 3, ADD 4, SUB 5, CMP 6, INC 7, DEC 8, PUSH 9, POP 10, TEST 11, LEA 12, JMP 13, CALL 14, conditional jump 15, FXCH 16, ADC 17, SBB 18, SHL 19, SHR 20, SAL 21, ROL 22, ROR 23, RCL 24, RCR 25, and 26 to 31 for other, non-pairable work. The V-slot instruction issues (`issue_v`) only when its class code is 0 to 16.
- R2: Pairing needs a U-slot class of 0 to 12 or 17 to 25. Any other U class issues alone with `consumed` = 1.
- R3: A V-slot instruction with both the memory-destination bit and the displacement bit set never pairs. Either bit alone does not block pairing.
- R4: Pairing is refused when the U-slot instruction has its destination enabled and the V-slot instruction reads that register through an enabled source A, source B, base or index field. Fields whose enable bit is clear never create a dependency.
- R5: If an enabled base or index register of the U-slot instruction was written by an instruction issued in the previous cycle, the block stalls for one cycle: `stall` = 1, no issue and `consumed` = 0. In the following cycle the same descriptor issues.
- R6: If only the V-slot instruction uses an address register written in the previous cycle, the U instruction issues alone without a stall. A V address register written by the U instruction of the same pair falls under R4, and then R5 applies in the next cycle.
- R7: An instruction that has the memory-operand bit set and is not MOV, PUSH or POP locks the pipes when it is part of a pair. With memory-cycle count N of 2 or 3 (the larger count if both lock), `stall` is 1 with nothing issued for N-1 cycles. The pair then issues with `consumed` = 2. A count of 0 or 1 pairs at once.
- R8: A U-slot instruction with the taken bit set never pairs.
- R9: While reset or `flush` is high, all outputs are 0. Both also clear the write history and any lockstep in progress, so no interlock follows a flush.
- R10: `consumed` always equals `issue_u` + `issue_v`. `issue_v` never rises without `issue_u`. `stall` never coincides with an issue. A V-slot valid without a U-slot valid issues nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Pipeline flush; clears history and lockstep |
| valid_u | input | 1 | Oldest descriptor is present |
| valid_v | input | 1 | Second descriptor is present |
| desc_u | input | 31 | Oldest instruction descriptor (R1 layout) |
| desc_v | input | 31 | Second instruction descriptor (R1 layout) |
| issue_u | output | 1 | Oldest instruction enters the U pipe this cycle |
| issue_v | output | 1 | Second instruction enters the V pipe this cycle |
| stall | output | 1 | Interlock or lockstep cycle; nothing issues |
| consumed | output | 2 | Number of descriptors taken this cycle |

## Verification
The properties assume that upstream holds both descriptors unchanged whenever `consumed` was 0. Under that assumption, the descriptors seen when a lockstep pair finally issues are the ones that started the lockstep. They also assume reset is applied from the first cycle. The stimulus follows these rules: it advances to new descriptors only after a cycle whose `consumed` value allows it, and it repeats the same pair through every stall cycle. Class and register sweeps use fields with clear enables wherever a dependency is not the object of the test, so that each sweep checks only one rule.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;
  parameter int NREG  = 8;
  parameter int RW    = $clog2(NREG);
  parameter int CLW   = 5;
  parameter int MCW   = 2;
  parameter int NSLOT = 2;

  localparam logic [CLW-1:0] C_MOV  = 5'd0;
  localparam logic [CLW-1:0] C_PUSH = 5'd9;
  localparam logic [CLW-1:0] C_POP  = 5'd10;
  localparam logic [CLW-1:0] C_LEA  = 5'd12;
  localparam logic [CLW-1:0] C_FXCH = 5'd16;
  localparam logic [CLW-1:0] C_ADC  = 5'd17;
  localparam logic [CLW-1:0] C_RCR  = 5'd25;

  typedef struct packed {
    logic           taken;
    logic [MCW-1:0] mcyc;
    logic           disp;
    logic           mdst;
    logic           mem;
    logic [RW-1:0]  idx;
    logic           idx_en;
    logic [RW-1:0]  base;
    logic           base_en;
    logic [RW-1:0]  sb;
    logic           sb_en;
    logic [RW-1:0]  sa;
    logic           sa_en;
    logic [RW-1:0]  dst;
    logic           dst_en;
    logic [CLW-1:0] cls;
  } idesc_t;

  localparam int DW = $bits(idesc_t);

  function automatic logic v_class_ok(input logic [CLW-1:0] c);
    return c <= C_FXCH;
  endfunction

  function automatic logic u_class_ok(input logic [CLW-1:0] c);
    return (c <= C_LEA) || ((c >= C_ADC) && (c <= C_RCR));
  endfunction

  function automatic logic locks_pipes(input idesc_t d);
    return d.mem && (d.cls != C_MOV) && (d.cls != C_PUSH) && (d.cls != C_POP);
  endfunction

  function automatic logic [NREG-1:0] reg_bit(input logic en, input logic [RW-1:0] r);
    logic [NREG-1:0] m;
    m = '0;
    if (en) m[r] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/di_slot_decode.sv
module di_slot_decode
  import dual_issue_pkg::*;
(
  input  idesc_t          d,
  output logic [NREG-1:0] wr_mask,
  output logic [NREG-1:0] rd_mask,
  output logic [NREG-1:0] ag_mask,
  output logic [MCW-1:0]  lock_len,
  output logic            no_v,
  output logic            no_pair_u
);
  logic [NREG-1:0] src_mask;

  always_comb begin
    wr_mask   = reg_bit(d.dst_en, d.dst);
    ag_mask   = reg_bit(d.base_en, d.base) | reg_bit(d.idx_en, d.idx);
    src_mask  = reg_bit(d.sa_en, d.sa) | reg_bit(d.sb_en, d.sb);
    rd_mask   = src_mask | ag_mask;
    lock_len  = locks_pipes(d) ? d.mcyc : '0;
    no_v      = !v_class_ok(d.cls) || (d.mdst && d.disp);
    no_pair_u = !u_class_ok(d.cls) || d.taken;
  end
endmodule

// File: rtl/di_agi_track.sv
module di_agi_track
  import dual_issue_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic [NREG-1:0] commit_wr,
  input  logic [NREG-1:0] ag_u,
  input  logic [NREG-1:0] ag_v,
  output logic            agi_u,
  output logic            agi_v
);
  logic [NREG-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst || flush) hist_q <= '0;
    else              hist_q <= commit_wr;
  end

  assign agi_u = |(ag_u & hist_q);
  assign agi_v = |(ag_v & hist_q);
endmodule

// File: rtl/di_lock_seq.sv
module di_lock_seq
  import dual_issue_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           flush,
  input  logic           start,
  input  logic [MCW-1:0] len,
  output logic           busy,
  output logic           last
);
  logic           act_q;
  logic [MCW-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      act_q <= 1'b0;
      rem_q <= '0;
    end else if (start) begin
      act_q <= 1'b1;
      rem_q <= len - MCW'(2);
    end else if (act_q) begin
      if (rem_q == '0) act_q <= 1'b0;
      else             rem_q <= rem_q - MCW'(1);
    end
  end

  assign busy = act_q;
  assign last = act_q && (rem_q == '0);
endmodule

// File: rtl/dual_issue_ctrl.sv
module dual_issue_ctrl
  import dual_issue_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          valid_u,
  input  logic          valid_v,
  input  logic [DW-1:0] desc_u,
  input  logic [DW-1:0] desc_v,
  output logic          issue_u,
  output logic          issue_v,
  output logic          stall,
  output logic [1:0]    consumed
);
  idesc_t          slot_d    [NSLOT];
  logic [NREG-1:0] wr_m      [NSLOT];
  logic [NREG-1:0] rd_m      [NSLOT];
  logic [NREG-1:0] ag_m      [NSLOT];
  logic [MCW-1:0]  lk_len    [NSLOT];
  logic            no_v      [NSLOT];
  logic            no_pair_u [NSLOT];

  assign slot_d[0] = idesc_t'(desc_u);
  assign slot_d[1] = idesc_t'(desc_v);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    di_slot_decode u_dec (
      .d         (slot_d[s]),
      .wr_mask   (wr_m[s]),
      .rd_mask   (rd_m[s]),
      .ag_mask   (ag_m[s]),
      .lock_len  (lk_len[s]),
      .no_v      (no_v[s]),
      .no_pair_u (no_pair_u[s])
    );
  end

  logic            agi_u, agi_v;
  logic [NREG-1:0] commit_wr;
  logic            raw_dep, pair_ok, need_lock, lock_start;
  logic            lk_busy, lk_last;
  logic [MCW-1:0]  pair_len;

  di_agi_track u_agi (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .commit_wr (commit_wr),
    .ag_u      (ag_m[0]),
    .ag_v      (ag_m[1]),
    .agi_u     (agi_u),
    .agi_v     (agi_v)
  );

  di_lock_seq u_lock (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .start (lock_start),
    .len   (pair_len),
    .busy  (lk_busy),
    .last  (lk_last)
  );

  always_comb begin
    raw_dep   = |(rd_m[1] & wr_m[0]);
    pair_ok   = valid_v && !no_pair_u[0] && !no_v[1] && !raw_dep && !agi_v;
    pair_len  = (lk_len[0] > lk_len[1]) ? lk_len[0] : lk_len[1];
    need_lock = pair_ok && (pair_len > MCW'(1));
  end

  always_comb begin
    issue_u    = 1'b0;
    issue_v    = 1'b0;
    stall      = 1'b0;
    lock_start = 1'b0;
    if (!(rst || flush)) begin
      if (lk_busy) begin
        if (lk_last) begin
          issue_u = 1'b1;
          issue_v = 1'b1;
        end else begin
          stall = 1'b1;
        end
      end else if (valid_u) begin
        if (agi_u) begin
          stall = 1'b1;
        end else if (need_lock) begin
          stall      = 1'b1;
          lock_start = 1'b1;
        end else begin
          issue_u = 1'b1;
          issue_v = pair_ok;
        end
      end
    end
  end

  assign commit_wr = (issue_u ? wr_m[0] : '0) | (issue_v ? wr_m[1] : '0);
  assign consumed  = 2'(issue_u) + 2'(issue_v);
endmodule

// File: rtl/di_issue_checker.sv
module di_issue_checker
  import dual_issue_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          flush,
  input logic          valid_u,
  input logic          valid_v,
  input logic [DW-1:0] desc_u,
  input logic [DW-1:0] desc_v,
  input logic          issue_u,
  input logic          issue_v,
  input logic          stall,
  input logic [1:0]    consumed
);
  idesc_t du, dv;
  assign du = idesc_t'(desc_u);
  assign dv = idesc_t'(desc_v);

  logic v_reads_u;
  assign v_reads_u = du.dst_en &&
    ((dv.sa_en && dv.sa == du.dst) || (dv.sb_en && dv.sb == du.dst) ||
     (dv.base_en && dv.base == du.dst) || (dv.idx_en && dv.idx == du.dst));

  logic long_lock;
  assign long_lock = (locks_pipes(du) && du.mcyc > 2'd1) ||
                     (locks_pipes(dv) && dv.mcyc > 2'd1);

  AST_V_CLASS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    issue_v |-> v_class_ok(dv.cls));  // R1
  AST_U_CLASS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    issue_v |-> u_class_ok(du.cls));  // R2
  AST_NO_DISP_MEMDST: assert property (@(posedge clk) disable iff (rst)
    issue_v |-> !(dv.mdst && dv.disp));  // R3
  AST_NO_RAW_PAIR: assert property (@(posedge clk) disable iff (rst)
    issue_v |-> !v_reads_u);  // R4
  AST_AGI_STALL: assert property (@(posedge clk) disable iff (rst)
    ($past(issue_u) && $past(du.dst_en) && valid_u && du.base_en &&
     du.base == $past(du.dst)) |-> !issue_u);  // R5
  AST_LOCK_PRECEDED: assert property (@(posedge clk) disable iff (rst)
    (issue_v && long_lock) |-> $past(stall));  // R7
  AST_TAKEN_SOLO: assert property (@(posedge clk) disable iff (rst)
    issue_v |-> !du.taken);  // R8
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (rst)
    flush |-> (!issue_u && !stall && consumed == 2'd0));  // R9
  AST_CONSUMED_SUM: assert property (@(posedge clk) disable iff (rst)
    consumed == 2'(issue_u) + 2'(issue_v));  // R10
  AST_V_WITH_U: assert property (@(posedge clk) disable iff (rst)
    issue_v |-> issue_u);  // R10
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    stall |-> !issue_u);  // R10
  AST_NEED_U_VALID: assert property (@(posedge clk) disable iff (rst)
    (!valid_u && !$past(stall)) |-> !issue_u);  // R10
endmodule

bind dual_issue_ctrl di_issue_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .flush    (flush),
  .valid_u  (valid_u),
  .valid_v  (valid_v),
  .desc_u   (desc_u),
  .desc_v   (desc_v),
  .issue_u  (issue_u),
  .issue_v  (issue_v),
  .stall    (stall),
  .consumed (consumed)
);

// File: tb/dual_issue_ctrl_bench.sv
module dual_issue_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst, flush, valid_u, valid_v;
  logic [30:0] desc_u, desc_v;
  logic        issue_u, issue_v, stall;
  logic [1:0]  consumed;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  dual_issue_ctrl u_dual_issue_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .valid_u(valid_u), .valid_v(valid_v),
    .desc_u(desc_u), .desc_v(desc_v), .issue_u(issue_u), .issue_v(issue_v),
    .stall(stall), .consumed(consumed)
  );

  function automatic logic [30:0] cl(int c);
    return 31'(c & 31);
  endfunction
  function automatic logic [30:0] wdst(logic [30:0] d, int r);
    d[5] = 1'b1; d[8:6] = 3'(r); return d;
  endfunction
  function automatic logic [30:0] wsa(logic [30:0] d, logic en, int r);
    d[9] = en; d[12:10] = 3'(r); return d;
  endfunction
  function automatic logic [30:0] wsb(logic [30:0] d, logic en, int r);
    d[13] = en; d[16:14] = 3'(r); return d;
  endfunction
  function automatic logic [30:0] wbase(logic [30:0] d, int r);
    d[17] = 1'b1; d[20:18] = 3'(r); return d;
  endfunction
  function automatic logic [30:0] wmem(logic [30:0] d, logic md, logic dp, int n);
    d[25] = 1'b1; d[26] = md; d[27] = dp; d[29:28] = 2'(n); return d;
  endfunction

  function automatic logic v_list(int c);
    return c <= 16;
  endfunction
  function automatic logic u_list(int c);
    return (c <= 12) || (c >= 17 && c <= 25);
  endfunction

  task automatic step(logic [30:0] a, logic [30:0] b, logic va, logic vb, logic fl);
    @(negedge clk);
    desc_u = a; desc_v = b; valid_u = va; valid_v = vb; flush = fl;
    #1;
  endtask

  task automatic expect_out(string req, logic s, logic iu, logic iv);
    logic [4:0] act, exp;
    act = {stall, issue_u, issue_v, consumed};
    exp = {s, iu, iv, 2'(iu) + 2'(iv)};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual stall/u/v/cons=%b expected %b", req, act, exp);
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [30:0] a, b;
    rst = 1'b1; flush = 1'b0; valid_u = 1'b0; valid_v = 1'b0;
    desc_u = '0; desc_v = '0;
    // R9: outputs quiet during reset even with work presented
    step(cl(4), cl(7), 1'b1, 1'b1, 1'b0);
    expect_out("R9 reset", 1'b0, 1'b0, 1'b0);
    step(cl(4), cl(7), 1'b1, 1'b1, 1'b0);
    expect_out("R9 reset", 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;
    step('0, '0, 1'b0, 1'b0, 1'b0);
    expect_out("R10 idle", 1'b0, 1'b0, 1'b0);
    // R10: V valid without U valid
    step(cl(0), cl(0), 1'b0, 1'b1, 1'b0);
    expect_out("R10 v_only", 1'b0, 1'b0, 1'b0);

    // R1 R2: full class sweep, no register fields
    for (int u = 0; u < 32; u++) begin
      for (int v = 0; v < 32; v++) begin
        step(cl(u), cl(v), 1'b1, 1'b1, 1'b0);
        expect_out("R1_R2 class", 1'b0, 1'b1, u_list(u) && v_list(v));
      end
    end

    // R4: dependency sweep over both sources and enables
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        for (int k = 0; k < 4; k++) begin
          logic en;
          en = k[0];
          a = wdst(cl(4), i);
          b = k[1] ? wsb(cl(5), en, j) : wsa(cl(5), en, j);
          step(a, b, 1'b1, 1'b1, 1'b0);
          expect_out("R4 raw", 1'b0, 1'b1, !(en && i == j));
        end
      end
    end
    // R4: disabled destination never blocks
    step(cl(4) | 31'(3 << 6), wsa(cl(5), 1'b1, 3), 1'b1, 1'b1, 1'b0);
    expect_out("R4 no_dst", 1'b0, 1'b1, 1'b1);

    // R3: memory destination / displacement combinations on V (MOV: no lock)
    for (int m = 0; m < 4; m++) begin
      step(cl(4), wmem(cl(0), m[1], m[0], 1), 1'b1, 1'b1, 1'b0);
      expect_out("R3 vmem", 1'b0, 1'b1, !(m[1] && m[0]));
    end
    step(wmem(cl(0), 1'b1, 1'b1, 1), cl(7), 1'b1, 1'b1, 1'b0);
    expect_out("R3 umem", 1'b0, 1'b1, 1'b1);

    // R8: taken transfer in U blocks pairing
    a = cl(4); a[30] = 1'b1;
    step(a, cl(7), 1'b1, 1'b1, 1'b0);
    expect_out("R8 taken", 1'b0, 1'b1, 1'b0);
    step(cl(4), cl(7), 1'b1, 1'b1, 1'b0);
    expect_out("R8 not_taken", 1'b0, 1'b1, 1'b1);

    // R5: interlock on U address register
    step(wdst(cl(0), 3), '0, 1'b1, 1'b0, 1'b0);
    expect_out("R5 load", 1'b0, 1'b1, 1'b0);
    step(wbase(cl(0), 3), '0, 1'b1, 1'b0, 1'b0);
    expect_out("R5 agi", 1'b1, 1'b0, 1'b0);
    step(wbase(cl(0), 3), '0, 1'b1, 1'b0, 1'b0);
    expect_out("R5 after", 1'b0, 1'b1, 1'b0);
    step(wdst(cl(0), 4), '0, 1'b1, 1'b0, 1'b0);
    expect_out("R5 load2", 1'b0, 1'b1, 1'b0);
    step(wbase(cl(0), 3), '0, 1'b1, 1'b0, 1'b0);
    expect_out("R5 other_reg", 1'b0, 1'b1, 1'b0);

    // R6: interlock seen only by V candidate
    step(wdst(cl(0), 5), '0, 1'b1, 1'b0, 1'b0);
    expect_out("R6 load", 1'b0, 1'b1, 1'b0);
    step(wsa(wdst(cl(4), 1), 1'b1, 1), wbase(cl(0), 5), 1'b1, 1'b1, 1'b0);
    expect_out("R6 v_agi", 1'b0, 1'b1, 1'b0);
    step(wbase(cl(0), 5), '0, 1'b1, 1'b0, 1'b0);
    expect_out("R6 v_moves", 1'b0, 1'b1, 1'b0);
    // R6: within-pair address dependency
    step(wdst(cl(0), 2), wbase(wdst(cl(0), 6), 2), 1'b1, 1'b1, 1'b0);
    expect_out("R6 pair_dep", 1'b0, 1'b1, 1'b0);
    step(wbase(wdst(cl(0), 6), 2), '0, 1'b1, 1'b0, 1'b0);
    expect_out("R6 pair_agi", 1'b1, 1'b0, 1'b0);
    step(wbase(wdst(cl(0), 6), 2), '0, 1'b1, 1'b0, 1'b0);
    expect_out("R6 pair_go", 1'b0, 1'b1, 1'b0);

    // R9: flush clears history
    step(wdst(cl(0), 3), '0, 1'b1, 1'b0, 1'b0);
    expect_out("R9 load", 1'b0, 1'b1, 1'b0);
    step(wbase(cl(0), 3), '0, 1'b1, 1'b0, 1'b1);
    expect_out("R9 flush", 1'b0, 1'b0, 1'b0);
    step(wbase(cl(0), 3), '0, 1'b1, 1'b0, 1'b0);
    expect_out("R9 no_agi", 1'b0, 1'b1, 1'b0);

    // R7: lockstep lengths
    for (int n = 3; n >= 0; n--) begin
      a = wmem(cl(4), 1'b0, 1'b0, n);
      for (int c = 1; c < n; c++) begin
        step(a, wdst(cl(7), 7), 1'b1, 1'b1, 1'b0);
        expect_out("R7 lock_stall", 1'b1, 1'b0, 1'b0);
      end
      step(a, wdst(cl(7), 7), 1'b1, 1'b1, 1'b0);
      expect_out("R7 lock_issue", 1'b0, 1'b1, 1'b1);
    end
    // R7: MOV with memory does not lock
    step(wmem(cl(0), 1'b0, 1'b0, 3), cl(7), 1'b1, 1'b1, 1'b0);
    expect_out("R7 mov_nolock", 1'b0, 1'b1, 1'b1);
    // R7: locking op in V
    b = wmem(cl(4), 1'b0, 1'b0, 2);
    step(cl(0), b, 1'b1, 1'b1, 1'b0);
    expect_out("R7 v_lock_stall", 1'b1, 1'b0, 1'b0);
    step(cl(0), b, 1'b1, 1'b1, 1'b0);
    expect_out("R7 v_lock_issue", 1'b0, 1'b1, 1'b1);
    // R7: unpaired locking U issues alone without stall
    step(wmem(cl(4), 1'b0, 1'b0, 3), '0, 1'b1, 1'b0, 1'b0);
    expect_out("R7 solo", 1'b0, 1'b1, 1'b0);
    // R9: flush aborts lockstep
    a = wmem(cl(4), 1'b0, 1'b0, 3);
    step(a, cl(7), 1'b1, 1'b1, 1'b0);
    expect_out("R7 abort_start", 1'b1, 1'b0, 1'b0);
    step(a, cl(7), 1'b1, 1'b1, 1'b1);
    expect_out("R9 abort_flush", 1'b0, 1'b0, 1'b0);
    step(cl(4), cl(7), 1'b1, 1'b1, 1'b0);
    expect_out("R9 after_abort", 1'b0, 1'b1, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule